// File: doc/BRIEF.md
# HDLC Transmit Framer

This block converts a byte stream from a message FIFO into the serial bit stream of one HDLC channel. It frames every message with flags and appends an optional frame check sequence. It inserts zeros so that frame content never shows six ones in a row, and it replaces a broken or cancelled frame with an abort. Between frames the line carries repeated flags. When the next message is already waiting, one flag both closes a frame and opens the next.

The framer advances one bit for every cycle in which `bit_en` is high, so the caller sets the line rate and any time-slot gaps. Bytes are taken on a valid/ready handshake. `in_ready` is raised only at the bit-time in which a byte is needed. A missing byte at that moment, in the middle of a frame, counts as a FIFO underflow. The checksum length is chosen per frame through `mode`.

Top module: `hdlc_tx_framer`

## Requirements
- R1: `mode` selects the check sequence: 0 = none, 1 = 16-bit, 2 = 32-bit, 3 = none. It is sampled when the first byte of a frame is accepted and holds for the whole frame.
- R2: After reset and whenever no frame is being sent, the output is repeated flags. A flag is the bit order 0,1,1,1,1,1,1,0. Every frame starts and ends with a flag, and no other frames appear on the line.
- R3: If a new message's first byte is valid when a closing flag ends, exactly one flag separates the two frames.
- R4: Payload bytes go out in message order, each least significant bit first.
- R5: After five consecutive 1 bits of payload or check sequence, one 0 bit is inserted. The line time of a frame is its content bits plus one bit per inserted zero. Flags and aborts are not stuffed.
- R6: The 16-bit check uses the reflected form of polynomial 0x1021 (feedback constant 0x8408). The 32-bit check uses the reflected form of 0x04C11DB7 (0xEDB88320). Both start from all ones and are computed over the payload. The complement is sent least significant bit first, right after the last payload byte.
- R7: A byte accepted with `in_abort` high is not sent. Eight 1 bits are sent instead, followed by flags. The rest of that message, up to its `in_last` byte, is accepted and discarded.
- R8: If `in_valid` is low when the next byte of an unfinished frame is needed, the frame is aborted as in R7. The rest of that message is discarded.
- R9: The output emits exactly one bit per `bit_en` cycle, with `tx_vld` high in the next cycle. `in_ready` is high only in a `bit_en` cycle, except while discarding.
- R10: During reset, `tx_vld` is 0, `tx_bit` is 1 and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Check-sequence selection for the next frame |
| bit_en | input | 1 | One line bit-time in this cycle |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Byte present |
| in_last | input | 1 | Byte is the last of its message |
| in_abort | input | 1 | Abort the message at this byte |
| in_ready | output | 1 | Byte is taken this cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_vld | output | 1 | `tx_bit` holds a new bit |

## Verification
The bench decodes the serial line with its own receiver. That receiver removes stuffing, finds flags and aborts, and recomputes each check sequence. Each mode is tried with five payload patterns: counting values, all ones, bytes equal to the flag, alternating bits, and 0xBF. Counting values exercise bit order and the CRC. The all-ones, flag-valued and 0xBF bytes force zero insertion at byte and check-sequence boundaries, and a wrong count shows up as a line-time mismatch. Back-to-back messages expose missing flag sharing, and messages after idle gaps show the pad fill. Aborts are placed on the first, a middle and the last byte, and stalls are placed in mid-message, with the bit strobe both continuous and gapped. These cases tell a request abort from an underflow abort and confirm that the dropped tail never reaches the line.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [7:0]  FLAG_PAT   = 8'h7E,
  parameter int          ABORT_BITS = 8,
  parameter logic [15:0] POLY16_R   = 16'h8408,
  parameter logic [31:0] POLY32_R   = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       bit_en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_abort,
  output logic       in_ready,
  output logic       tx_bit,
  output logic       tx_vld
);

  localparam int CNTW = 6;

  typedef enum logic [1:0] {S_FLAG, S_DATA, S_FCS, S_ABORT} st_t;

  st_t             st, st_n;
  logic [31:0]     sh, sh_n, crc, crc_nx, fcs;
  logic [CNTW-1:0] cnt, len, len_n;
  logic [2:0]      ones;
  logic [1:0]      mode_q;
  logic            stuff, skip, last_q;
  logic            step, at_end, content, want, take, fb, has_fcs;

  assign step     = bit_en && !stuff;
  assign at_end   = cnt == len - 1'b1;
  assign content  = (st == S_DATA) || (st == S_FCS);
  assign want     = (st == S_FLAG && !skip) || (st == S_DATA && !last_q);
  assign in_ready = skip || (step && at_end && want);
  assign take     = in_valid && in_ready && !skip;
  assign fb       = crc[0] ^ sh[0];
  assign has_fcs  = (mode_q == 2'd1) || (mode_q == 2'd2);

  always_comb begin
    if (mode_q == 2'd1)
      crc_nx = {16'h0, {1'b0, crc[15:1]} ^ (fb ? POLY16_R : 16'h0)};
    else
      crc_nx = {1'b0, crc[31:1]} ^ (fb ? POLY32_R : 32'h0);
    fcs = (mode_q == 2'd1) ? {16'h0, ~crc_nx[15:0]} : ~crc_nx;
  end

  always_comb begin
    st_n = st;
    if (at_end) begin
      case (st)
        S_FLAG:  st_n = take ? (in_abort ? S_ABORT : S_DATA) : S_FLAG;
        S_DATA:  if (last_q) st_n = has_fcs ? S_FCS : S_FLAG;
                 else        st_n = (take && !in_abort) ? S_DATA : S_ABORT;
        default: st_n = S_FLAG;
      endcase
    end
    sh_n  = {1'b0, sh[31:1]};
    len_n = len;
    if (at_end) begin
      case (st_n)
        S_DATA:  begin sh_n = {24'h0, in_data}; len_n = CNTW'(8); end
        S_FCS:   begin sh_n = fcs; len_n = (mode_q == 2'd1) ? CNTW'(16) : CNTW'(32); end
        S_ABORT: begin sh_n = '1; len_n = CNTW'(ABORT_BITS); end
        default: begin sh_n = {24'h0, FLAG_PAT}; len_n = CNTW'(8); end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_FLAG;
      sh     <= {24'h0, FLAG_PAT};
      cnt    <= '0;
      len    <= CNTW'(8);
      ones   <= '0;
      stuff  <= 1'b0;
      skip   <= 1'b0;
      last_q <= 1'b0;
      mode_q <= 2'd0;
      crc    <= '1;
      tx_bit <= 1'b1;
      tx_vld <= 1'b0;
    end else begin
      tx_vld <= bit_en;
      if (bit_en) tx_bit <= stuff ? 1'b0 : sh[0];
      if (bit_en && stuff) begin
        stuff <= 1'b0;
        ones  <= '0;
      end
      if (step) begin
        st  <= st_n;
        sh  <= sh_n;
        len <= len_n;
        cnt <= at_end ? '0 : cnt + 1'b1;
        if (content) ones <= sh[0] ? ones + 3'd1 : 3'd0;
        else         ones <= '0;
        stuff <= content && sh[0] && (ones == 3'd4) && (st_n != S_ABORT);
        if (st == S_DATA) crc <= crc_nx;
        if (st == S_FLAG && take) begin
          crc    <= '1;
          mode_q <= mode;
        end
        if (take) last_q <= in_last;
        if (at_end && st_n == S_ABORT && !skip) skip <= !(take && in_last);
      end
      if (skip && in_valid && in_last) skip <= 1'b0;
    end
  end

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff) |=> (tx_vld && !tx_bit)); // R5
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd5); // R5
  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == S_ABORT) |=> tx_bit); // R7
  AST_NO_FRAME_WHILE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (st != S_DATA)); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_DATA) |-> $stable(mode_q)); // R1
  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !skip) |-> bit_en); // R9

endmodule

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [1:0] mode = 0;
  logic bit_en = 0, in_valid = 0, in_last = 0, in_abort = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tx_bit, tx_vld;

  hdlc_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_abort(in_abort),
    .in_ready(in_ready), .tx_bit(tx_bit), .tx_vld(tx_vld));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [7:0] ev_data [0:63][0:15];
  int ev_len [0:63];
  int ev_kind [0:63];
  int ev_mode [0:63];
  bit ev_b2b [0:63];
  int n_ev = 0;

  int ones_run = 0, blen = 0, rlen = 0, gap = 0, got_ev = 0, first_n = 0, strobe_bad = 0, cyc = 0;
  bit abt = 0, en_q = 0, gappy = 0;
  bit dbuf [0:1023];
  bit xb [0:255];

  function automatic logic [7:0] pat(int kind, int i, int e);
    case (kind)
      0: return 8'(i * 29 + e * 7 + 1);
      1: return 8'hFF;
      2: return 8'h7E;
      3: return 8'(8'hA5 ^ i);
      default: return 8'hBF;
    endcase
  endfunction

  task automatic frame_check(input int clen, input int rraw);
    int e, fl, nb, mism, st, run;
    logic [31:0] crc;
    e = got_ev;
    got_ev++;
    if (e >= n_ev || ev_kind[e] != 0) begin
      chk(0, "R2", "frame where none or abort expected", e, n_ev);
      return;
    end
    fl = (ev_mode[e] == 1) ? 16 : (ev_mode[e] == 2) ? 32 : 0;
    nb = ev_len[e] * 8;
    chk(clen == nb + fl, "R1", "frame content bits", clen, nb + fl);
    crc = (fl == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
    for (int i = 0; i < nb; i++) begin
      bit b, f;
      b = ev_data[e][i / 8][i % 8];
      xb[i] = b;
      f = crc[0] ^ b;
      crc = crc >> 1;
      if (f) crc = crc ^ ((fl == 16) ? 32'h8408 : 32'hEDB88320);
    end
    for (int i = 0; i < fl; i++) xb[nb + i] = ~crc[i];
    if (clen == nb + fl) begin
      mism = 0;
      for (int i = 0; i < nb; i++) if (dbuf[i] != xb[i]) mism++;
      chk(mism == 0, "R4", "payload bit mismatches", mism, 0);
      mism = 0;
      for (int i = 0; i < fl; i++) if (dbuf[nb + i] != xb[nb + i]) mism++;
      chk(mism == 0, "R6", "check-sequence bit mismatches", mism, 0);
    end
    st = 0; run = 0;
    for (int i = 0; i < nb + fl; i++) begin
      if (xb[i]) begin
        run++;
        if (run == 5) begin st++; run = 0; end
      end else run = 0;
    end
    chk(rraw == nb + fl + st, "R5", "frame line bits", rraw, nb + fl + st);
    if (ev_b2b[e]) chk(gap == 1, "R3", "flags between frames", gap, 1);
  endtask

  task automatic flag_seen();
    int clen, rraw, e;
    clen = blen - 7;
    rraw = rlen - 8;
    if (abt) begin
      e = got_ev;
      got_ev++;
      chk(e < n_ev && ev_kind[e] != 0, (e < n_ev && ev_kind[e] == 2) ? "R8" : "R7",
          "abort seen, event kind", e < n_ev ? ev_kind[e] : -1, 1);
      gap = 1;
    end else if (clen > 0) begin
      frame_check(clen, rraw);
      gap = 1;
    end else gap++;
    blen = 0; rlen = 0; abt = 0;
  endtask

  task automatic decode(input bit b);
    logic [7:0] fp;
    fp = 8'h7E;
    if (first_n < 8) begin
      chk(b == fp[first_n], "R2", "first flag bit", b, fp[first_n]);
      first_n++;
    end
    rlen++;
    if (b) begin
      ones_run++;
      if (ones_run >= 7) abt = 1;
      if (blen < 1024) dbuf[blen] = 1'b1;
      blen++;
    end else begin
      if (ones_run == 6) flag_seen();
      else if (ones_run != 5) begin
        if (blen < 1024) dbuf[blen] = 1'b0;
        blen++;
      end
      ones_run = 0;
    end
  endtask

  always @(posedge clk) begin
    en_q <= bit_en;
    cyc <= cyc + 1;
  end

  always @(negedge clk) bit_en = rst_n && (!gappy || (cyc % 3 != 1));

  always @(negedge clk) if (rst_n) begin
    if (tx_vld !== en_q) strobe_bad++;
    if (tx_vld) decode(tx_bit);
  end

  task automatic send(input int len, input int md, input int kind,
                      input int ab_at, input int st_at, input bit b2b);
    int e;
    bit acc;
    e = n_ev;
    n_ev++;
    ev_len[e] = len; ev_mode[e] = md; ev_b2b[e] = b2b;
    ev_kind[e] = (ab_at >= 0) ? 1 : (st_at >= 0) ? 2 : 0;
    for (int i = 0; i < len; i++) ev_data[e][i] = pat(kind, i, e);
    mode = 2'(md);
    for (int i = 0; i < len; i++) begin
      if (i == st_at) begin
        in_valid = 0;
        repeat (120) @(negedge clk);
      end
      in_valid = 1;
      in_data = ev_data[e][i];
      in_last = (i == len - 1);
      in_abort = (i == ab_at);
      do begin
        #1 acc = in_ready;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 0; in_last = 0; in_abort = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", got_ev, n_ev);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx_vld == 0, "R10", "tx_vld in reset", tx_vld, 0);
    chk(tx_bit == 1, "R10", "tx_bit in reset", tx_bit, 1);
    chk(in_ready == 0, "R10", "in_ready in reset", in_ready, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    for (int md = 0; md < 3; md++) begin
      for (int k = 0; k < 5; k++) send(1 + k * 3, md, k, -1, -1, k != 0);
      repeat (30) @(negedge clk);
    end
    gappy = 1;
    send(5, 1, 0, -1, -1, 0);
    send(4, 2, 1, -1, -1, 1);
    send(3, 3, 3, -1, -1, 1);
    gappy = 0;
    repeat (20) @(negedge clk);
    send(6, 1, 0, 2, -1, 0);
    send(3, 1, 4, -1, -1, 0);
    send(4, 2, 3, 3, -1, 0);
    send(2, 2, 1, -1, -1, 0);
    send(5, 0, 4, 0, -1, 0);
    send(4, 0, 0, -1, -1, 0);
    send(6, 2, 0, -1, 3, 0);
    send(3, 2, 2, -1, -1, 0);
    gappy = 1;
    send(6, 1, 1, -1, 2, 0);
    send(4, 1, 0, -1, -1, 0);
    gappy = 0;
    repeat (300) @(negedge clk);
    chk(got_ev == n_ev, "R2", "events decoded", got_ev, n_ev);
    chk(strobe_bad == 0, "R9", "strobe misalignments", strobe_bad, 0);
    finish_run();
  end
endmodule